// File: doc/BRIEF.md
# Fourth-Power Feedforward Carrier Phase Estimator

This block recovers the carrier phase of a stream of complex QPSK samples with no feedback loop. Every accepted sample is raised to the fourth power, which maps all four QPSK data phases onto the same point, so only four times the carrier phase is left. Those powers are summed over a sliding window of 2N+1 accepted symbols. The angle of the negated window sum, divided by four, is the phase estimate for the symbol in the middle of that window.

The sample sent out with each estimate is that middle symbol, N accepted symbols behind the newest one, so a downstream derotator and slicer get the pair already lined up. Because nothing is fed back, the angle computation is a fully pipelined CORDIC. Its depth only adds latency and does not narrow the tolerable laser linewidth. Cycles without `in_valid` are skipped: the window counts symbols, not clock cycles.

Top module: `qpsk_phase_est`

## Requirements
- R1: After reset, `out_valid` stays low until 2N+1 valid symbols have been accepted. The first estimate belongs to the symbol with index N (counting from 0 after reset).
- R2: With each estimate, `out_i`/`out_q` carry the input symbol whose index is N lower than the newest symbol in the window, i.e. the window centre.
- R3: `out_phase` is a signed PW-bit fraction of π (value·π/2^(PW-1) radians). It equals one quarter of the angle of −S, within ±3 LSB, where S is the sum of (I+jQ)^4 over the 2N+1 window symbols. The angle range is (−π, π], so the output range is about ±π/4.
- R4: Cycles with `in_valid` low are ignored whatever `in_i`/`in_q` carry. They neither enter the window nor move the output sequence.
- R5: An estimate appears exactly ITER+4 clock edges after the edge that accepted the newest symbol of its window.
- R6: Once the window is full, each accepted symbol yields exactly one output, in input order.
- R7: A reset in mid-stream discards every pending estimate and all window contents. Outputs resume only after 2N+1 new symbols, using only post-reset symbols.
- R8: For QPSK symbols A·e^{j(θ+π/4+kπ/2)} with arbitrary data k and |θ| < π/4, the estimate equals θ within 40 LSB.
- R9: The window sum does not overflow for full-scale inputs. 2N+1 symbols of (−2^(W−1), −2^(W−1)) give an estimate of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Symbol strobe for `in_i`/`in_q` |
| in_i | input | W | In-phase component, two's complement |
| in_q | input | W | Quadrature component, two's complement |
| out_valid | output | 1 | Estimate and aligned symbol are valid |
| out_i | output | W | In-phase component of the window-centre symbol |
| out_q | output | W | Quadrature component of the window-centre symbol |
| out_phase | output | PW | Phase estimate, signed fraction of π |

## Verification
A corrupted window, such as a stale entry that is never subtracted or a sum that wrapped, shows up as a wrong `out_phase` on the very next estimate. It stays wrong for all following estimates until the faulty entry would have aged out, and forever if the running sum itself is off. A wrong fill count or a mis-tapped centre register is visible at once on the first post-reset output, either through its timing or through a centre symbol that does not match. A wrong quadrant pre-rotation or arctangent constant moves the phase of every estimate whose negated sum lies in the affected half-plane, ITER+4 edges after the symbol that completed its window.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Arctangent of 2^-idx, scaled so that pi equals 2^ze.
    function automatic int atan_code(input int idx, input int ze);
        real ang;
        ang = $atan(1.0 / (2.0 ** idx));
        return $rtoi(ang / PI_R * (2.0 ** ze) + 0.5);
    endfunction

    // Width that holds the sum of taps signed words of p4w bits.
    function automatic int acc_width(input int p4w, input int taps);
        return p4w + $clog2(taps);
    endfunction

endpackage

// File: rtl/cpe_pow4.sv
module cpe_pow4 #(
    parameter int W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [W-1:0]   in_i,
    input  logic signed [W-1:0]   in_q,
    output logic                  p_valid,
    output logic signed [4*W-1:0] p_re,
    output logic signed [4*W-1:0] p_im,
    output logic signed [W-1:0]   p_si,
    output logic signed [W-1:0]   p_sq
);
    localparam int P2W = 2 * W + 1;
    localparam int P4W = 4 * W;

    typedef struct packed {
        logic                  v0;
        logic signed [W-1:0]   i0;
        logic signed [W-1:0]   q0;
        logic                  v1;
        logic signed [P2W-1:0] a1;
        logic signed [P2W-1:0] b1;
        logic signed [W-1:0]   i1;
        logic signed [W-1:0]   q1;
        logic                  v2;
        logic signed [P4W-1:0] re2;
        logic signed [P4W-1:0] im2;
        logic signed [W-1:0]   i2;
        logic signed [W-1:0]   q2;
    } pw_st_t;

    pw_st_t st_d, st_q;
    logic signed [P2W-1:0] xe, ye;
    logic signed [P4W-1:0] ae, be;

    always_comb begin
        st_d = st_q;
        // capture
        st_d.v0 = in_valid;
        if (in_valid) begin
            st_d.i0 = in_i;
            st_d.q0 = in_q;
        end
        // square: (x+jy)^2 = (x^2-y^2) + j2xy
        xe = P2W'($signed(st_q.i0));
        ye = P2W'($signed(st_q.q0));
        st_d.v1 = st_q.v0;
        st_d.a1 = xe * xe - ye * ye;
        st_d.b1 = (xe * ye) <<< 1;
        st_d.i1 = st_q.i0;
        st_d.q1 = st_q.q0;
        // square again
        ae = P4W'($signed(st_q.a1));
        be = P4W'($signed(st_q.b1));
        st_d.v2  = st_q.v1;
        st_d.re2 = ae * ae - be * be;
        st_d.im2 = (ae * be) <<< 1;
        st_d.i2  = st_q.i1;
        st_d.q2  = st_q.q1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p_valid = st_q.v2;
    assign p_re    = st_q.re2;
    assign p_im    = st_q.im2;
    assign p_si    = st_q.i2;
    assign p_sq    = st_q.q2;

    // The modulus of a fourth power never exceeds 2^(4W-2).
    assert_pow_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v2 |-> (st_q.re2 <= (P4W'(1) <<< (P4W-2)) && st_q.re2 >= -(P4W'(1) <<< (P4W-2))));
endmodule

// File: rtl/cpe_window.sv
module cpe_window #(
    parameter int W   = 5,
    parameter int P4W = 20,
    parameter int N   = 4,
    parameter int SW  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  p_valid,
    input  logic signed [P4W-1:0] p_re,
    input  logic signed [P4W-1:0] p_im,
    input  logic signed [W-1:0]   p_si,
    input  logic signed [W-1:0]   p_sq,
    output logic                  w_valid,
    output logic signed [SW-1:0]  w_re,
    output logic signed [SW-1:0]  w_im,
    output logic signed [W-1:0]   w_si,
    output logic signed [W-1:0]   w_sq
);
    localparam int L    = 2 * N + 1;
    localparam int CNTW = $clog2(L + 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(L);
    localparam logic signed [SW-1:0] BOUND = SW'(longint'(L) << (4 * W - 2));

    typedef struct packed {
        logic [L-1:0][P4W-1:0] hre;
        logic [L-1:0][P4W-1:0] him;
        logic [N-1:0][W-1:0]   smi;
        logic [N-1:0][W-1:0]   smq;
        logic [CNTW-1:0]       cnt;
        logic signed [SW-1:0]  sum_re;
        logic signed [SW-1:0]  sum_im;
        logic                  v;
        logic signed [W-1:0]   ci;
        logic signed [W-1:0]   cq;
    } win_st_t;

    win_st_t st_d, st_q;
    logic signed [SW-1:0] add_re, add_im, sub_re, sub_im;

    always_comb begin
        st_d   = st_q;
        st_d.v = 1'b0;
        add_re = SW'(p_re);
        add_im = SW'(p_im);
        sub_re = SW'($signed(st_q.hre[L-1]));
        sub_im = SW'($signed(st_q.him[L-1]));
        if (p_valid) begin
            st_d.sum_re = st_q.sum_re + add_re - sub_re;
            st_d.sum_im = st_q.sum_im + add_im - sub_im;
            st_d.hre[0] = p_re;
            st_d.him[0] = p_im;
            for (int j = 1; j < L; j++) begin
                st_d.hre[j] = st_q.hre[j-1];
                st_d.him[j] = st_q.him[j-1];
            end
            // centre symbol is the one N accepted symbols back
            st_d.ci     = $signed(st_q.smi[N-1]);
            st_d.cq     = $signed(st_q.smq[N-1]);
            st_d.smi[0] = p_si;
            st_d.smq[0] = p_sq;
            for (int j = 1; j < N; j++) begin
                st_d.smi[j] = st_q.smi[j-1];
                st_d.smq[j] = st_q.smq[j-1];
            end
            if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
            st_d.v = (st_q.cnt >= FULL - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign w_valid = st_q.v;
    assign w_re    = st_q.sum_re;
    assign w_im    = st_q.sum_im;
    assign w_si    = st_q.ci;
    assign w_sq    = st_q.cq;

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v |-> (st_q.sum_re <= BOUND && st_q.sum_re >= -BOUND &&
                    st_q.sum_im <= BOUND && st_q.sum_im >= -BOUND));

    assert_gap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !p_valid |=> ($stable(st_q.sum_re) && $stable(st_q.sum_im) && !st_q.v));
endmodule

// File: rtl/cpe_cordic.sv
module cpe_cordic #(
    parameter int W    = 5,
    parameter int SW   = 24,
    parameter int PW   = 12,
    parameter int ITER = 12,
    parameter int GB   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_valid,
    input  logic signed [SW-1:0] w_re,
    input  logic signed [SW-1:0] w_im,
    input  logic signed [W-1:0]  w_si,
    input  logic signed [W-1:0]  w_sq,
    output logic                 o_valid,
    output logic signed [W-1:0]  o_si,
    output logic signed [W-1:0]  o_sq,
    output logic signed [PW-1:0] o_phase
);
    localparam int CW = SW + 2 + GB;   // room for shift, rotation and gain
    localparam int ZE = PW;            // pi is 2^ZE in the angle register
    localparam int ZW = ZE + 3;
    localparam int G  = 3;             // angle/4 in units of pi/2^(PW-1)
    localparam logic signed [ZW-1:0] HALF_PI = ZW'(longint'(1) << (ZE - 1));
    localparam logic signed [ZW-1:0] LIM     = ZW'(longint'(5) << (ZE - 2));

    typedef struct packed {
        logic                 v;
        logic signed [CW-1:0] x;
        logic signed [CW-1:0] y;
        logic signed [ZW-1:0] z;
        logic signed [W-1:0]  si;
        logic signed [W-1:0]  sq;
    } cst_t;

    cst_t pre_d, pre_q;
    cst_t chain [ITER];
    logic signed [CW-1:0] nx, ny;

    // negate the sum, then fold the left half-plane onto the right
    always_comb begin
        nx       = -(CW'(w_re) <<< GB);
        ny       = -(CW'(w_im) <<< GB);
        pre_d.v  = w_valid;
        pre_d.si = w_si;
        pre_d.sq = w_sq;
        if (nx < 0) begin
            if (ny >= 0) begin
                pre_d.x = ny;
                pre_d.y = -nx;
                pre_d.z = HALF_PI;
            end else begin
                pre_d.x = -ny;
                pre_d.y = nx;
                pre_d.z = -HALF_PI;
            end
        end else begin
            pre_d.x = nx;
            pre_d.y = ny;
            pre_d.z = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    for (genvar k = 0; k < ITER; k++) begin : g_stage
        localparam logic signed [ZW-1:0] ANG = ZW'(cpe_pkg::atan_code(k, ZE));
        cst_t src, cur_d, cur_q;

        if (k == 0) begin : g_first
            assign src = pre_q;
        end else begin : g_next
            assign src = chain[k-1];
        end

        always_comb begin
            cur_d = src;
            if (src.y >= 0) begin
                cur_d.x = src.x + (src.y >>> k);
                cur_d.y = src.y - (src.x >>> k);
                cur_d.z = src.z + ANG;
            end else begin
                cur_d.x = src.x - (src.y >>> k);
                cur_d.y = src.y + (src.x >>> k);
                cur_d.z = src.z - ANG;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cur_q <= '0;
            else        cur_q <= cur_d;
        end

        assign chain[k] = cur_q;

        assert_x_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cur_q.v |-> cur_q.x >= 0);
    end

    logic signed [ZW-1:0] zr;
    assign zr      = chain[ITER-1].z + ZW'(1 << (G - 1));
    assign o_phase = PW'(zr >>> G);
    assign o_valid = chain[ITER-1].v;
    assign o_si    = chain[ITER-1].si;
    assign o_sq    = chain[ITER-1].sq;

    assert_angle_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chain[ITER-1].v |-> (chain[ITER-1].z <= LIM && chain[ITER-1].z >= -LIM));
endmodule

// File: rtl/qpsk_phase_est.sv
module qpsk_phase_est #(
    parameter int W    = 5,
    parameter int N    = 4,
    parameter int PW   = 12,
    parameter int ITER = 12,
    parameter int GB   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_i,
    input  logic signed [W-1:0]  in_q,
    output logic                 out_valid,
    output logic signed [W-1:0]  out_i,
    output logic signed [W-1:0]  out_q,
    output logic signed [PW-1:0] out_phase
);
    localparam int P4W  = 4 * W;
    localparam int L    = 2 * N + 1;
    localparam int SW   = cpe_pkg::acc_width(P4W, L);
    localparam int CNTW = $clog2(L + 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(L);

    logic                  p_valid;
    logic signed [P4W-1:0] p_re, p_im;
    logic signed [W-1:0]   p_si, p_sq;
    logic                  w_valid;
    logic signed [SW-1:0]  w_re, w_im;
    logic signed [W-1:0]   w_si, w_sq;

    cpe_pow4 #(.W(W)) u_pow (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .p_valid(p_valid), .p_re(p_re), .p_im(p_im), .p_si(p_si), .p_sq(p_sq)
    );

    cpe_window #(.W(W), .P4W(P4W), .N(N), .SW(SW)) u_win (
        .clk(clk), .rst_n(rst_n),
        .p_valid(p_valid), .p_re(p_re), .p_im(p_im), .p_si(p_si), .p_sq(p_sq),
        .w_valid(w_valid), .w_re(w_re), .w_im(w_im), .w_si(w_si), .w_sq(w_sq)
    );

    cpe_cordic #(.W(W), .SW(SW), .PW(PW), .ITER(ITER), .GB(GB)) u_ang (
        .clk(clk), .rst_n(rst_n),
        .w_valid(w_valid), .w_re(w_re), .w_im(w_im), .w_si(w_si), .w_sq(w_sq),
        .o_valid(out_valid), .o_si(out_i), .o_sq(out_q), .o_phase(out_phase)
    );

    // independent count of accepted symbols, guarding the output gate
    logic [CNTW-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (in_valid && seen_q != FULL) seen_d = seen_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    assert_fill_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen_q == FULL);
endmodule

// File: tb/sim_qpsk_phase_est.sv
`timescale 1ns/1ps
module sim_qpsk_phase_est;
    localparam int  W    = 5;
    localparam int  N    = 4;
    localparam int  PW   = 12;
    localparam int  ITER = 12;
    localparam int  L    = 2 * N + 1;
    localparam int  LAT  = ITER + 4;
    localparam int  TOL  = 3;
    localparam int  TTOL = 40;
    localparam real PI   = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0]  in_i = '0, in_q = '0;
    logic                 out_valid;
    logic signed [W-1:0]  out_i, out_q;
    logic signed [PW-1:0] out_phase;

    always #4 clk = ~clk;

    qpsk_phase_est #(.W(W), .N(N), .PW(PW), .ITER(ITER)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_phase(out_phase)
    );

    typedef struct {
        int     ei;
        int     eq;
        int     ph;
        longint ecyc;
        bit     qp;
        int     th;
        string  tag;
    } item_t;

    item_t  sb[$];
    int     hi[$], hq[$];
    longint ecnt = 0;
    int     n_chk = 0, n_err = 0, n_out = 0;
    bit     done = 1'b0;

    always @(posedge clk) ecnt <= ecnt + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int to_code(input real ang);
        real v;
        v = ang * (2.0 ** (PW - 1)) / PI;
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic bit near(input int got, input int exp, input int tol);
        int d, q;
        q = 1 << (PW - 2);   // estimate is defined modulo pi/2
        d = got - exp;
        while (d > q / 2)  d -= q;
        while (d < -q / 2) d += q;
        return (d <= tol) && (d >= -tol);
    endfunction

    task automatic send(input int si, input int sq, input string tag,
                        input bit qp, input real th);
        @(negedge clk);
        in_valid = 1'b1;
        in_i = W'(si);
        in_q = W'(sq);
        hi.push_back(si);
        hq.push_back(sq);
        if (hi.size() >= L) begin
            item_t  it;
            longint sr, sm, a, b, ny, nx;
            sr = 0;
            sm = 0;
            for (int j = hi.size() - L; j < hi.size(); j++) begin
                a = longint'(hi[j]) * hi[j] - longint'(hq[j]) * hq[j];
                b = 2 * longint'(hi[j]) * hq[j];
                sr += a * a - b * b;
                sm += 2 * a * b;
            end
            ny = -sm;
            nx = -sr;
            it.ei   = hi[hi.size() - 1 - N];
            it.eq   = hq[hq.size() - 1 - N];
            it.ph   = to_code($atan2(real'(ny), real'(nx)) / 4.0);
            it.ecyc = ecnt + 1 + LAT;
            it.qp   = qp;
            it.th   = to_code(th);
            it.tag  = tag;
            sb.push_back(it);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_i = W'($urandom);
            in_q = W'($urandom);
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        in_valid = 1'b0;
        hi.delete();
        hq.delete();
        sb.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_rand(input string tag);
        send($urandom_range(0, 31) - 16, $urandom_range(0, 31) - 16, tag, 1'b0, 0.0);
    endtask

    task automatic send_qpsk(input real th);
        real a;
        a = th + PI / 4.0 + real'($urandom_range(0, 3)) * PI / 2.0;
        send($rtoi(11.0 * $cos(a) + (($cos(a) >= 0.0) ? 0.5 : -0.5)),
             $rtoi(11.0 * $sin(a) + (($sin(a) >= 0.0) ? 0.5 : -0.5)),
             "R8", 1'b1, th);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            n_out++;
            if (sb.size() == 0) begin
                chk(1'b0, "R6", "output with no expected item", n_out, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(int'(out_i) == it.ei, "R2", "centre I", out_i, it.ei);
                chk(int'(out_q) == it.eq, "R2", "centre Q", out_q, it.eq);
                chk(near(int'(out_phase), it.ph, TOL), it.tag, "phase", out_phase, it.ph);
                chk(ecnt == it.ecyc, "R5", "latency edge", ecnt, it.ecyc);
                if (it.qp)
                    chk(near(int'(out_phase), it.th, TTOL), "R8", "carrier angle",
                        out_phase, it.th);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "WD", "watchdog expired", ecnt, 0);
        finish_run();
    end

    initial begin
        int n0;
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R1: window not yet full
        n0 = n_out;
        repeat (L - 1) send_rand("R1");
        gap(LAT + 3);
        chk(n_out == n0, "R1", "outputs before window full", n_out - n0, 0);
        send_rand("R1");
        gap(LAT + 3);
        chk(n_out == n0 + 1, "R1", "first output once full", n_out - n0, 1);

        // R3: back-to-back random symbols
        repeat (150) send_rand("R3");

        // R4: gaps with garbage on the data inputs
        repeat (100) begin
            send_rand("R4");
            gap($urandom_range(0, 3));
        end
        gap(LAT + 4);
        chk(sb.size() == 0, "R6", "pending items after drain", sb.size(), 0);

        // R7: reset in mid-stream
        repeat (6) send_rand("R3");
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid after mid-stream reset", out_valid, 0);
        n0 = n_out;
        repeat (L - 1) send_rand("R7");
        gap(LAT + 3);
        chk(n_out == n0, "R7", "outputs before refill", n_out - n0, 0);
        repeat (20) send_rand("R7");
        gap(LAT + 4);

        // R8: modulation stripped, carrier angle recovered
        do_reset();
        repeat (40) send_qpsk(0.3);
        gap(LAT + 4);
        do_reset();
        repeat (40) send_qpsk(-0.5);
        gap(LAT + 4);

        // R9: full-scale corner symbols
        do_reset();
        repeat (L + 3) send(-16, -16, "R9", 1'b0, 0.0);
        gap(LAT + 4);
        repeat (L) send(15, -16, "R9", 1'b0, 0.0);
        gap(LAT + 4);

        chk(sb.size() == 0, "R6", "pending items at end", sb.size(), 0);
        finish_run();
    end
endmodule